// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block gathers 32 asynchronous interrupt sources and presents them to a processor through two independent banks of configuration. One bank drives the normal interrupt line. The other drives the fast interrupt line. Both banks watch the same 32 inputs after a shared two-flop synchroniser. Each bank sets, for each source, whether the source is enabled, whether it is sensed as a level or as an edge, and which polarity counts as active.

Edge events are held in a sticky pending bit until software writes a one to that bit of the acknowledge register. Level sources track their input directly. Each bank's status word is its pending bits gated by its enable mask. The bank's interrupt line is the OR of that status. Each bank also gives the number of its lowest pending source, with a valid flag, so the handler can pick the lowest-numbered source first.

A simple single-cycle register bus reaches the configuration. Writes take effect at the clock edge where select and write are high. Read data is registered and appears one cycle after the request.

Top module: `dual_bank_intc`

## Requirements
- R1: The register word offsets in the normal bank are: synchronised raw inputs 0x00, enable mask 0x04, acknowledge 0x08, sense mode 0x0C, polarity 0x10, status 0x14. Address bit 5 selects the fast bank, which uses the same layout at 0x20 to 0x34. The mask, mode and polarity registers of each bank read back what was written and are independent of the other bank.
- R2: The status of each source is its pending bit AND its mask bit. A mask bit of 1 enables the source and 0 blocks it.
- R3: A sense-mode bit of 0 selects level sensing. A bit of 1 selects edge sensing.
- R4: A polarity bit of 0 means active-high (level) or rising (edge). A bit of 1 means active-low (level) or falling (edge).
- R5: In edge mode a detected edge sets a pending bit that stays set after the input returns to idle. Writing 1 to that bit of the acknowledge register clears it, and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the edge wins.
- R6: In level mode the pending bit follows the polarity-corrected input one cycle after the synchroniser. An acknowledge write has no lasting effect while the input stays active.
- R7: The normal and fast interrupt outputs are registered ORs of their own bank's status, one cycle after that status. Configuring one bank never raises the other bank's output.
- R8: Each bank outputs a 5-bit index and a valid flag. A cycle after the status changes, the index is the number of the lowest set status bit. The flag is high exactly when the status is nonzero.
- R9: After reset, every mask, mode, polarity and pending bit is 0. Both interrupt outputs and both valid flags are low, and every register reads as zero.
- R10: Each input passes through two flip-flops before sensing. A pulse held across two rising clock edges is always captured. The raw register returns the synchronised inputs.
- R11: Read data appears on the cycle after a read request. The acknowledge register and unused offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous interrupt sources |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| irq_idx | output | 5 | Lowest pending source, normal bank |
| irq_idx_vld | output | 1 | Normal bank has a pending source |
| fiq_idx | output | 5 | Lowest pending source, fast bank |
| fiq_idx_vld | output | 1 | Fast bank has a pending source |

## Verification
The bench checks falling-edge sensing against an input that starts active-high and then drops. A design that inverted the wrong operand would latch no edge at all, or would latch on the restore. It checks that an edge stays latched after its short pulse ends and is not disturbed by a zero or a neighbour's acknowledge bit. A design that was not sticky, or that cleared by the register address alone, would lose the event. In level mode it writes an acknowledge while the input is active and expects the status to return at once. It also raises a source in the fast bank alone to catch crossed bank decode. Randomised mode, polarity, mask and input patterns check the lowest-index output against a reference model, which catches a finder that scans from the top.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_AW = 6;
  localparam int NBANK  = 2;

  typedef enum logic [2:0] {
    SEL_RAW  = 3'd0,
    SEL_ENA  = 3'd1,
    SEL_ACK  = 3'd2,
    SEL_TRIG = 3'd3,
    SEL_POL  = 3'd4,
    SEL_STAT = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_s,
  input  logic [NSRC-1:0] wdata,
  input  logic            wr_mask,
  input  logic            wr_mode,
  input  logic            wr_pol,
  input  logic [NSRC-1:0] ack_v,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] mode_q,
  output logic [NSRC-1:0] pol_q,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] stat
);
  logic [NSRC-1:0] src_d;
  logic [NSRC-1:0] act_now;
  logic [NSRC-1:0] act_old;
  logic [NSRC-1:0] edge_hit;
  logic [NSRC-1:0] pend_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      src_d  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_mode) mode_q <= wdata;
      if (wr_pol)  pol_q  <= wdata;
      src_d  <= src_s;
      pend_q <= pend_nx;
    end
  end

  // Both samples use the current polarity, so a polarity write alone never fakes an edge.
  assign act_now  = src_s ^ pol_q;
  assign act_old  = src_d ^ pol_q;
  assign edge_hit = act_now & ~act_old;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      if (mode_q[i]) pend_nx[i] = edge_hit[i] | (pend_q[i] & ~ack_v[i]);
      else           pend_nx[i] = act_now[i];
    end
  end

  assign stat = pend_q & mask_q;
endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
  parameter int NSRC = 32,
  parameter int IW   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] vec,
  output logic [IW-1:0]   idx,
  output logic            hit
);
  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int SYNC_STG  = 2,
  localparam int IW       = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      src_i,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [NSRC-1:0]      bus_wdata,
  output logic [NSRC-1:0]      bus_rdata,
  output logic                 irq_o,
  output logic                 fiq_o,
  output logic [IW-1:0]        irq_idx,
  output logic                 irq_idx_vld,
  output logic [IW-1:0]        fiq_idx,
  output logic                 fiq_idx_vld
);
  logic [NSRC-1:0] src_sync;
  logic            bk;
  reg_sel_e        rs;
  logic            wr_go;
  logic            rd_go;

  logic [NSRC-1:0] mask_v [NBANK];
  logic [NSRC-1:0] mode_v [NBANK];
  logic [NSRC-1:0] pol_v  [NBANK];
  logic [NSRC-1:0] pend_v [NBANK];
  logic [NSRC-1:0] stat_v [NBANK];
  logic [NSRC-1:0] ack_v  [NBANK];
  logic            out_q  [NBANK];
  logic [IW-1:0]   idx_q  [NBANK];
  logic            vld_q  [NBANK];

  intc_sync #(.WIDTH(NSRC), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (src_i),
    .q   (src_sync)
  );

  assign bk    = bus_addr[REG_AW-1];
  assign rs    = reg_sel_e'(bus_addr[REG_AW-2:2]);
  assign wr_go = bus_sel & bus_wr;
  assign rd_go = bus_sel & ~bus_wr;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          hit;
    logic [IW-1:0] idx_c;
    logic          any_c;

    assign hit      = wr_go && (bk == 1'(b));
    assign ack_v[b] = (hit && rs == SEL_ACK) ? bus_wdata : '0;

    intc_bank #(.NSRC(NSRC)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .src_s   (src_sync),
      .wdata   (bus_wdata),
      .wr_mask (hit && rs == SEL_ENA),
      .wr_mode (hit && rs == SEL_TRIG),
      .wr_pol  (hit && rs == SEL_POL),
      .ack_v   (ack_v[b]),
      .mask_q  (mask_v[b]),
      .mode_q  (mode_v[b]),
      .pol_q   (pol_v[b]),
      .pend_q  (pend_v[b]),
      .stat    (stat_v[b])
    );

    intc_lowest #(.NSRC(NSRC), .IW(IW)) u_low (
      .vec (stat_v[b]),
      .idx (idx_c),
      .hit (any_c)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[b] <= 1'b0;
        idx_q[b] <= '0;
        vld_q[b] <= 1'b0;
      end else begin
        out_q[b] <= |stat_v[b];
        idx_q[b] <= idx_c;
        vld_q[b] <= any_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_go) begin
      case (rs)
        SEL_RAW:  bus_rdata <= src_sync;
        SEL_ENA:  bus_rdata <= mask_v[bk];
        SEL_TRIG: bus_rdata <= mode_v[bk];
        SEL_POL:  bus_rdata <= pol_v[bk];
        SEL_STAT: bus_rdata <= stat_v[bk];
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq_o       = out_q[0];
  assign fiq_o       = out_q[1];
  assign irq_idx     = idx_q[0];
  assign irq_idx_vld = vld_q[0];
  assign fiq_idx     = idx_q[1];
  assign fiq_idx_vld = vld_q[1];
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NSRC = 32,
  parameter int IW   = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [IW-1:0]   irq_idx,
  input logic            irq_idx_vld,
  input logic            fiq_idx_vld,
  input logic [NSRC-1:0] src_sync,
  input logic [NSRC-1:0] stat_irq,
  input logic [NSRC-1:0] pend_irq,
  input logic [NSRC-1:0] mode_irq,
  input logic [NSRC-1:0] pol_irq,
  input logic [NSRC-1:0] ack_irq
);
  assert_reset_clean_R9: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !fiq_o && !irq_idx_vld && !fiq_idx_vld));

  assert_vld_matches_out_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_idx_vld == irq_o) && (fiq_idx_vld == fiq_o));

  assert_lowest_first_R8: assert property (@(posedge clk) disable iff (rst)
    irq_idx_vld |-> ((($past(stat_irq) >> irq_idx) & NSRC'(1)) != '0) &&
                    (($past(stat_irq) & ((NSRC'(1) << irq_idx) - NSRC'(1))) == '0));

  assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(pend_irq & mode_irq & ~ack_irq) & ~pend_irq) == '0));

  assert_level_follows_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(~mode_irq) & (pend_irq ^ $past(src_sync ^ pol_irq))) == '0));
endmodule

bind dual_bank_intc intc_chk #(.NSRC(NSRC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .irq_idx     (irq_idx),
  .irq_idx_vld (irq_idx_vld),
  .fiq_idx_vld (fiq_idx_vld),
  .src_sync    (src_sync),
  .stat_irq    (stat_v[0]),
  .pend_irq    (pend_v[0]),
  .mode_irq    (mode_v[0]),
  .pol_irq     (pol_v[0]),
  .ack_irq     (ack_v[0])
);

// File: tb/dual_bank_intc_bench.sv
module dual_bank_intc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  typedef struct packed {
    logic [31:0] mode;
    logic [31:0] pol;
    logic [31:0] mask;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic [31:0] stat;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0100, 32'h0000_0100},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 32'h8000_0001},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'h0000_000F},
    '{32'h0000_0000, 32'h0000_00FF, 32'h0000_00F0, 32'h0000_0000, 32'h0000_0030, 32'h0000_00C0},
    '{32'h0000_FFFF, 32'h0000_0000, 32'hFFFF_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_0000},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_F000, 32'h0000_F000, 32'h0000_0000},
    '{32'h0000_0F00, 32'h0000_0A00, 32'h0000_0F00, 32'h0000_0000, 32'h0000_0F00, 32'h0000_0500}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, irq_idx_vld, fiq_idx_vld;
  logic [4:0]  irq_idx, fiq_idx;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] lcg = 32'h1357_9BDF;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rst(rst), .src_i(src_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o),
    .irq_idx(irq_idx), .irq_idx_vld(irq_idx_vld),
    .fiq_idx(fiq_idx), .fiq_idx_vld(fiq_idx_vld)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [4:0] low_idx(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) low_idx = 5'(i);
    if (v == '0) low_idx = '0;
  endfunction

  function automatic logic [31:0] next_rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic run_case(input logic [5:0] base, input vec_t v, input string tag);
    logic [31:0] rd;
    logic        o, vl;
    logic [4:0]  ix;
    src_i = v.src_a;
    wait_cyc(4);
    bus_write(base + 6'h0C, v.mode);
    bus_write(base + 6'h10, v.pol);
    bus_write(base + 6'h04, v.mask);
    wait_cyc(4);
    bus_write(base + 6'h08, 32'hFFFF_FFFF);
    wait_cyc(2);
    src_i = v.src_b;
    wait_cyc(6);
    o  = base[5] ? fiq_o : irq_o;
    vl = base[5] ? fiq_idx_vld : irq_idx_vld;
    ix = base[5] ? fiq_idx : irq_idx;
    bus_read(base + 6'h14, rd);
    check(rd == v.stat, {"R2/R3/R4 status ", tag}, rd, v.stat);
    check(o == (|v.stat), {"R7 line ", tag}, 32'(o), 32'(|v.stat));
    check(vl == (|v.stat), {"R8 valid ", tag}, 32'(vl), 32'(|v.stat));
    check(ix == low_idx(v.stat), {"R8 index ", tag}, 32'(ix), 32'(low_idx(v.stat)));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    src_i = '0;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d cycles expected=finish", WDOG_CYC);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    vec_t        rv;
    do_reset();
    check(irq_o == 1'b0 && fiq_o == 1'b0, "R9 lines low after reset", 32'({irq_o, fiq_o}), 32'h0);

    // Table walk on the normal bank
    for (int k = 0; k < 8; k++) run_case(6'h00, TBL[k], $sformatf("tbl%0d", k));

    // Pseudo-random patterns, alternating banks, against the reference model
    for (int k = 0; k < 24; k++) begin
      logic [31:0] aa, bb;
      rv.mode  = next_rnd();
      rv.pol   = next_rnd();
      rv.mask  = next_rnd();
      rv.src_a = next_rnd();
      rv.src_b = next_rnd();
      aa = rv.src_a ^ rv.pol;
      bb = rv.src_b ^ rv.pol;
      rv.stat  = rv.mask & ((rv.mode & ~aa & bb) | (~rv.mode & bb));
      run_case((k % 2) ? 6'h20 : 6'h00, rv, $sformatf("rnd%0d", k));
      if (k == 0) begin
        bus_read(6'h00, rd);
        check(rd == rv.src_b, "R10 raw view of synchronised inputs", rd, rv.src_b);
      end
    end

    // Reset state of every register in both banks
    do_reset();
    for (int a = 0; a < 16; a++) begin
      bus_read(6'(a * 4), rd);
      check(rd == 32'h0, $sformatf("R9 reg %02h after reset", a * 4), rd, 32'h0);
    end
    check(!irq_idx_vld && !fiq_idx_vld, "R9 valid flags low", 32'({irq_idx_vld, fiq_idx_vld}), 32'h0);

    // Readback and bank independence
    bus_write(6'h04, 32'hA5A5_0F0F);
    bus_write(6'h24, 32'h1234_5678);
    bus_write(6'h2C, 32'h0000_FF00);
    bus_write(6'h30, 32'h00FF_0000);
    bus_read(6'h04, rd); check(rd == 32'hA5A5_0F0F, "R1 irq mask readback", rd, 32'hA5A5_0F0F);
    bus_read(6'h24, rd); check(rd == 32'h1234_5678, "R1 fiq mask readback", rd, 32'h1234_5678);
    bus_read(6'h2C, rd); check(rd == 32'h0000_FF00, "R1 fiq mode readback", rd, 32'h0000_FF00);
    bus_read(6'h30, rd); check(rd == 32'h00FF_0000, "R1 fiq polarity readback", rd, 32'h00FF_0000);
    bus_read(6'h0C, rd); check(rd == 32'h0, "R1 irq mode untouched", rd, 32'h0);
    bus_write(6'h08, 32'hFFFF_FFFF);
    bus_read(6'h08, rd); check(rd == 32'h0, "R11 acknowledge reads zero", rd, 32'h0);
    bus_read(6'h18, rd); check(rd == 32'h0, "R11 unused offset reads zero", rd, 32'h0);

    // Sticky edge with a two-cycle pulse
    do_reset();
    bus_write(6'h0C, 32'h0000_0020);
    bus_write(6'h04, 32'h0000_0020);
    @(negedge clk); src_i[5] = 1'b1;
    wait_cyc(2);    src_i[5] = 1'b0;
    wait_cyc(6);
    bus_read(6'h14, rd); check(rd == 32'h20, "R10/R5 short pulse latched", rd, 32'h20);
    check(irq_o == 1'b1, "R5 line held after pulse", 32'(irq_o), 32'h1);
    bus_write(6'h08, 32'h0);
    wait_cyc(2);
    bus_read(6'h14, rd); check(rd == 32'h20, "R5 zero ack ignored", rd, 32'h20);
    bus_write(6'h08, 32'hFFFF_FFDF);
    wait_cyc(2);
    bus_read(6'h14, rd); check(rd == 32'h20, "R5 other-bit ack ignored", rd, 32'h20);
    bus_write(6'h08, 32'h0000_0020);
    wait_cyc(3);
    bus_read(6'h14, rd); check(rd == 32'h0, "R5 ack clears", rd, 32'h0);
    check(irq_o == 1'b0, "R5 line drops after ack", 32'(irq_o), 32'h0);

    // Level mode ignores acknowledge while active
    bus_write(6'h04, 32'h0000_0080);
    src_i[7] = 1'b1;
    wait_cyc(6);
    bus_write(6'h08, 32'h0000_0080);
    wait_cyc(1);
    bus_read(6'h14, rd); check(rd == 32'h80, "R6 level survives ack", rd, 32'h80);
    src_i[7] = 1'b0;
    wait_cyc(6);
    bus_read(6'h14, rd); check(rd == 32'h0, "R6 level follows input low", rd, 32'h0);

    // Fast bank alone
    bus_write(6'h04, 32'h0);
    bus_write(6'h24, 32'h0004_0008);
    src_i = 32'h0004_0008;
    wait_cyc(6);
    check(fiq_o == 1'b1 && irq_o == 1'b0, "R7 only fast line raised", 32'({fiq_o, irq_o}), 32'h2);
    check(fiq_idx_vld && fiq_idx == 5'd3, "R8 fast lowest index", 32'(fiq_idx), 32'd3);
    bus_read(6'h34, rd); check(rd == 32'h0004_0008, "R1 fast status", rd, 32'h0004_0008);
    bus_read(6'h14, rd); check(rd == 32'h0, "R7 normal status clear", rd, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule